// File: doc/BRIEF.md
# Coherent Dual-Channel Sample Latch

This block sits between two free-running 12-bit converters and the register-read side of a serial host interface. Each cycle in which `smp_valid` is high, it receives one current code and one voltage code taken at the same instant. The host reads the most recent pair as four read-only bytes. Because the pair held for the host changes only when the host has finished reading it, all four bytes always belong to one sample instant.

The converters run on their own schedule and take no account of host reads. After reset the first sample goes straight into the visible snapshot. Samples that arrive later wait in a single pending slot, and each new one replaces the last. The pending pair moves into the snapshot only when the host has read the four data bytes in strictly descending address order. The current code is saturated at 0x0F00. The voltage code passes through unchanged.

Top module: `pair_snapshot_latch`

## Requirements
- R1: After reset the snapshot holds zero: every data byte reads 0x00.
- R2: `rd_data` follows `rd_addr` combinationally. 0x0203 returns the current code bits 11:8 in its low nibble, and 0x0202 returns current bits 7:0. 0x0201 and 0x0200 return the same two slices of the voltage code. The upper nibble of 0x0203 and 0x0201 is always 0. Any other address returns 0x00.
- R3: A current code above 0x0F00 is stored as 0x0F00. A code at or below 0x0F00 is stored unchanged.
- R4: The voltage code is stored without clamping, and 0x0FFF can be read back.
- R5: When the block is open to new data, a valid sample enters the snapshot at the next clock edge. The block is open after reset, and after a completed read sequence that found nothing pending.
- R6: When the block is not open to new data, a valid sample does not change the snapshot until a read sequence completes.
- R7: Each newer sample overwrites the pending pair. On completion the latest pending pair is released.
- R8: A sequence completes only on the four reads 0x0203, 0x0202, 0x0201, 0x0200 in that order, with no other read in between. A read that breaks the order sends the tracker back to expecting 0x0203. If that read was itself 0x0203, it counts as the first step. A partial sequence releases nothing.
- R9: If a sequence completes in the same cycle as a valid sample, the incoming sample goes into the snapshot and the older pending pair is dropped.
- R10: A sequence that completes with nothing pending leaves the snapshot unchanged and opens the block to new data (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A new sample pair is present this cycle |
| smp_cur | input | 12 | Current-channel conversion code |
| smp_vol | input | 12 | Voltage-channel conversion code |
| rd_stb | input | 1 | Host register read this cycle |
| rd_addr | input | 16 | Address of the host read |
| rd_data | output | 8 | Byte returned for `rd_addr` |

## Verification
A converter sample and the final 0x0200 read of an ordered sequence can land in the same clock cycle. In that cycle the completion logic and the sample-capture logic both want to write the snapshot. The bench provokes this by raising `smp_valid` in the same cycle as the closing read, while an older pair is already pending. It judges the outcome twice. The closing read must still return the old voltage byte. The next full sequence must return the sample that arrived in the collision cycle, and never the older pending pair.

// File: rtl/pl_pkg.sv
package pl_pkg;

  // Saturate a conversion code at an upper limit; codes never wrap.
  function automatic logic [11:0] sat_code(input logic [11:0] code,
                                           input logic [11:0] limit);
    return (code > limit) ? limit : code;
  endfunction

  // Right-justify a 12-bit code into a 16-bit register image.
  function automatic logic [15:0] widen16(input logic [11:0] code);
    return {4'b0000, code};
  endfunction

endpackage

// File: rtl/pl_seq_tracker.sv
module pl_seq_tracker #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [15:0] BASE   = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              seq_done
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(BASE) + ADDR_W'(3);

  logic [1:0]        step;
  logic [ADDR_W-1:0] want_addr;
  logic              hit;

  assign want_addr = TOP_ADDR - ADDR_W'(step);
  assign hit       = rd_stb && (rd_addr == want_addr);
  assign seq_done  = hit && (step == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= 2'd0;
    end else if (rd_stb) begin
      if (hit)                      step <= step + 2'd1;
      else if (rd_addr == TOP_ADDR) step <= 2'd1;
      else                          step <= 2'd0;
    end
  end
endmodule

// File: rtl/pl_sample_store.sv
module pl_sample_store #(
  parameter int unsigned CODE_W    = 12,
  parameter logic [11:0] CUR_LIMIT = 12'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_cur,
  input  logic [CODE_W-1:0] smp_vol,
  input  logic              seq_done,
  output logic [CODE_W-1:0] snap_cur,
  output logic [CODE_W-1:0] snap_vol,
  output logic              snap_load,
  output logic              release_ok
);
  import pl_pkg::*;

  logic [CODE_W-1:0] in_cur;
  logic [CODE_W-1:0] pend_cur, pend_vol;
  logic              pend_full;
  logic              take_direct, take_pend;

  assign in_cur      = sat_code(smp_cur, CUR_LIMIT);
  assign take_direct = smp_valid && (release_ok || seq_done);
  assign take_pend   = seq_done && !smp_valid && pend_full;
  assign snap_load   = take_direct || take_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_cur <= '0;
      snap_vol <= '0;
    end else if (take_direct) begin
      snap_cur <= in_cur;
      snap_vol <= smp_vol;
    end else if (take_pend) begin
      snap_cur <= pend_cur;
      snap_vol <= pend_vol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cur  <= '0;
      pend_vol  <= '0;
      pend_full <= 1'b0;
    end else if (seq_done) begin
      pend_full <= 1'b0;
    end else if (smp_valid && !release_ok) begin
      pend_cur  <= in_cur;
      pend_vol  <= smp_vol;
      pend_full <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       release_ok <= 1'b1;
    else if (take_direct)             release_ok <= 1'b0;
    else if (seq_done && !pend_full)  release_ok <= 1'b1;
  end
endmodule

// File: rtl/pl_byte_view.sv
module pl_byte_view #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [15:0] BASE   = 16'h0200
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [11:0]       snap_cur,
  input  logic [11:0]       snap_vol,
  output logic [7:0]        rd_data
);
  import pl_pkg::*;

  localparam int unsigned LANES = 4;

  logic [LANES-1:0][7:0] lane;
  logic [15:0]           img_vol, img_cur;
  logic [ADDR_W-1:0]     off;

  assign img_vol = widen16(snap_vol);
  assign img_cur = widen16(snap_cur);
  assign off     = rd_addr - ADDR_W'(BASE);

  // Lane k holds byte (k mod 2) of voltage (k<2) or current (k>=2).
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k < 2) begin : g_v
      assign lane[k] = img_vol[8*k +: 8];
    end else begin : g_c
      assign lane[k] = img_cur[8*(k-2) +: 8];
    end
  end

  assign rd_data = (off < ADDR_W'(LANES)) ? lane[off[1:0]] : 8'h00;
endmodule

// File: rtl/pair_snapshot_latch.sv
module pair_snapshot_latch #(
  parameter int unsigned CODE_W    = 12,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE      = 16'h0200,
  parameter logic [11:0] CUR_LIMIT = 12'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_cur,
  input  logic [CODE_W-1:0] smp_vol,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic              seq_done;
  logic              snap_load;
  logic              release_ok;
  logic [CODE_W-1:0] snap_cur, snap_vol;

  pl_seq_tracker #(.ADDR_W(ADDR_W), .BASE(BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .seq_done(seq_done)
  );

  pl_sample_store #(.CODE_W(CODE_W), .CUR_LIMIT(CUR_LIMIT)) u_store (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_cur(smp_cur),
    .smp_vol(smp_vol), .seq_done(seq_done), .snap_cur(snap_cur),
    .snap_vol(snap_vol), .snap_load(snap_load), .release_ok(release_ok)
  );

  pl_byte_view #(.ADDR_W(ADDR_W), .BASE(BASE)) u_view (
    .rd_addr(rd_addr), .snap_cur(snap_cur), .snap_vol(snap_vol),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/pl_latch_checker.sv
module pl_latch_checker #(
  parameter int unsigned CODE_W    = 12,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE      = 16'h0200,
  parameter logic [11:0] CUR_LIMIT = 12'hF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [CODE_W-1:0] smp_vol,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic [CODE_W-1:0] snap_cur,
  input logic [CODE_W-1:0] snap_vol,
  input logic              snap_load,
  input logic              seq_done,
  input logic              release_ok
);
  localparam logic [ADDR_W-1:0] A_VHI = ADDR_W'(BASE) + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'(BASE) + ADDR_W'(3);

  assert_cur_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    snap_cur <= CUR_LIMIT);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> $stable(snap_cur) && $stable(snap_vol));

  assert_order_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> rd_stb && (rd_addr == ADDR_W'(BASE)));

  assert_msb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && (rd_addr == A_VHI || rd_addr == A_CHI) |-> rd_data[7:4] == 4'h0);

  assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && smp_valid |=> snap_vol == $past(smp_vol));

  assert_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_ok && smp_valid |=> !release_ok && snap_vol == $past(smp_vol));
endmodule

bind pair_snapshot_latch pl_latch_checker #(
  .CODE_W(CODE_W), .ADDR_W(ADDR_W), .BASE(BASE), .CUR_LIMIT(CUR_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_vol(smp_vol),
  .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
  .snap_cur(snap_cur), .snap_vol(snap_vol), .snap_load(snap_load),
  .seq_done(seq_done), .release_ok(release_ok)
);

// File: tb/tb_pair_snapshot_latch.sv
module tb_pair_snapshot_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_cur = '0, smp_vol = '0;
  logic        rd_stb = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  pair_snapshot_latch dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_cur(smp_cur),
    .smp_vol(smp_vol), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Monitor: every read cycle pops one expected byte.
  always @(negedge clk) begin
    if (rst_n && rd_stb) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read addr=%h got=%h exp=none", rd_addr, rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL %s addr=%h got=%h exp=%h", t, rd_addr, rd_data, e);
        end
      end
    end
  end

  task automatic put_sample(input logic [11:0] c, input logic [11:0] v);
    @(posedge clk); #1;
    smp_valid = 1'b1; smp_cur = c; smp_vol = v;
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_stb = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_stb = 1'b0;
  endtask

  task automatic rd_with_sample(input logic [15:0] a, input logic [7:0] e,
                                input logic [11:0] c, input logic [11:0] v,
                                input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_stb = 1'b1; rd_addr = a;
    smp_valid = 1'b1; smp_cur = c; smp_vol = v;
    @(posedge clk); #1;
    rd_stb = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic rd_all(input logic [11:0] c, input logic [11:0] v, input string t);
    rd(16'h0203, {4'h0, c[11:8]}, t);
    rd(16'h0202, c[7:0], t);
    rd(16'h0201, {4'h0, v[11:8]}, t);
    rd(16'h0200, v[7:0], t);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd_all(12'h000, 12'h000, "R1 reset");
    put_sample(12'h123, 12'h456);
    rd_all(12'h123, 12'h456, "R5 R2 first sample");
    put_sample(12'h0AB, 12'h0CD);
    rd_all(12'h0AB, 12'h0CD, "R10 reopened");

    // Held state: first loads, later ones go pending and overwrite.
    put_sample(12'h111, 12'h222);
    put_sample(12'h333, 12'h444);
    put_sample(12'hFFF, 12'hFFF);
    rd(16'h0203, 8'h01, "R8 partial");
    rd(16'h0202, 8'h11, "R8 partial");
    rd(16'h0200, 8'h22, "R8 out of order");
    rd(16'h0202, 8'h11, "R8 no start");
    rd(16'h0201, 8'h02, "R8 no start");
    rd(16'h0200, 8'h22, "R8 no start");
    rd_all(12'h111, 12'h222, "R6 held");
    rd_all(12'hF00, 12'hFFF, "R7 R3 R4 latest clamped");

    // Restart on 0x0203 counts as first step.
    put_sample(12'h010, 12'h020);
    put_sample(12'hF01, 12'h001);
    rd(16'h0203, 8'h00, "R8 restart");
    rd(16'h0202, 8'h10, "R8 restart");
    rd(16'h0203, 8'h00, "R8 restart");
    rd(16'h0202, 8'h10, "R8 restart");
    rd(16'h0201, 8'h00, "R8 restart");
    rd(16'h0200, 8'h20, "R8 restart");
    rd_all(12'hF00, 12'h001, "R8 R3 released");

    // Boundary: exactly the limit passes.
    put_sample(12'hF00, 12'h000);
    rd_all(12'hF00, 12'h000, "R3 at limit");

    // Collision: completion and sample in the same cycle.
    put_sample(12'h555, 12'h666);
    put_sample(12'h777, 12'h888);
    rd(16'h0203, 8'h05, "R9 pre");
    rd(16'h0202, 8'h55, "R9 pre");
    rd(16'h0201, 8'h06, "R9 pre");
    rd_with_sample(16'h0200, 8'h66, 12'h999, 12'hAAA, "R9 closing read");
    rd_all(12'h999, 12'hAAA, "R9 incoming wins");

    rd(16'h0100, 8'h00, "R2 other address");
    rd(16'h0204, 8'h00, "R2 other address");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule